// File: doc/BRIEF.md
# Four-Phase Oversampling Data Recovery

This block recovers a serial bit stream whose phase against the local receive clock is unknown. The block runs on a clock four times the bit rate, so each bit period (one receive cycle) yields four samples, one for each of the 0°, 90°, 180° and 270° phases. Every sample passes through a two-register chain. A per-phase transition detector then flags the phases at which the line changed. Decision logic locks onto the phase opposite the transitions, which is the point furthest from any edge. The block emits one recovered bit per bit period, with a valid strobe and the chosen phase code.

Whole-period sample words wait in a delay line until the decision is available. The recovered bit therefore comes out a fixed number of receive cycles after the data entered. The phase choice moves only after a transition has been seen at one phase in several edge-bearing periods in a row. A single jittered transition cannot pull the sampling point away.

Top module: `quad_phase_rx`

## Requirements
- R1: `din` is sampled at every rising clock edge while `rst` is low. Edge 0 is the first edge with reset low, and sample k belongs to bit period k/4 at phase code k mod 4 (0 = 0°, 1 = 90°, 2 = 180°, 3 = 270°). Each sample reaches the decision logic through two cascaded registers.
- R2: A transition is flagged at phase p of a period when that period's sample at p differs from the sample taken just before it. For phase 0 this is phase 3 of the previous period, and a logic 0 before the first period. When several phases flag in one period, the lowest phase code counts as that period's edge phase.
- R3: Once locked, `phase_o` equals (edge phase + 2) mod 4, the phase 180° away from the transitions.
- R4: `phase_o` takes a new value only when the same edge phase has occurred in 4 edge-bearing periods in a row. A period with no transition neither extends nor breaks the run, and a period whose edge phase differs starts a new run of one.
- R5: After reset, and for as long as no transition has been seen, `phase_o` is 0, `vld` is low and `dout` is 0.
- R6: Period m is decided at clock edge 4m+5, one decision edge per bit period. Edge 1 carries a dummy decision for a period with no transitions. `vld` is a one-clock pulse after a decision edge, high only if a transition was found in some earlier decided period, and it stays low at every other edge.
- R7: At decision edge 4m+5, `dout` takes sample 4(m-4)+s, where s is the value of `phase_o` just before that edge. For m < 4 it takes 0. The sample taken at the phase-0 instant of a period therefore appears 21 clocks later: five receive cycles plus the output register.
- R8: `dout` and `phase_o` change only on decision edges and hold between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock, four cycles per bit period |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Serial data line of unknown phase |
| dout | output | 1 | Recovered data bit |
| vld | output | 1 | One-clock strobe per bit period when a recovered bit is valid |
| phase_o | output | 2 | Selected sampling phase, 0 to 3 for 0° to 270° |

## Verification
The bench locks onto edges at phases 1, 2 and 3 and checks that the selected phase lands 180° away. A design that selected the edge phase itself, or rotated the wrong way, would report the wrong code and recover bits sampled right at transitions. It injects a single displaced transition and a three-period run at a new phase. It also holds the line quiet between edge-bearing periods, so a design that relocked too early or let quiet periods reset the run count would show a phase change one period off. Random data after a mid-stream reset exercises the five-period delay: an off-by-one in the delay line or the period boundary shows up as `dout` mismatches, and a design that strobed before the first transition fails on `vld`.

// File: rtl/quad_phase_rx.sv
module quad_phase_rx #(
  parameter int LOCK_CNT = 4,
  parameter int DELAY    = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       din,
  output logic       dout,
  output logic       vld,
  output logic [1:0] phase_o
);
  localparam int RW = $clog2(LOCK_CNT + 1);

  logic          s1, s2, last3, seen;
  logic [1:0]    pc, ep, cand, sel;
  logic [2:0]    w;
  logic [3:0]    word, e;
  logic [RW-1:0] run, nrun;
  logic [3:0]    dly [DELAY];
  logic          tick;

  assign tick    = (pc == 2'd3);
  assign word    = {s2, w};
  assign e       = word ^ {word[2:0], last3};
  assign phase_o = sel;

  always_comb begin
    if (e[0])      ep = 2'd0;
    else if (e[1]) ep = 2'd1;
    else if (e[2]) ep = 2'd2;
    else           ep = 2'd3;
  end

  assign nrun = (run != '0 && ep == cand)
              ? ((run == RW'(LOCK_CNT)) ? run : run + 1'b1)
              : RW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1    <= 1'b0;
      s2    <= 1'b0;
      pc    <= 2'd2;
      w     <= '0;
      last3 <= 1'b0;
      cand  <= '0;
      run   <= '0;
      sel   <= '0;
      seen  <= 1'b0;
      dout  <= 1'b0;
      vld   <= 1'b0;
      for (int i = 0; i < DELAY; i++) dly[i] <= '0;
    end else begin
      s1  <= din;
      s2  <= s1;
      pc  <= pc + 2'd1;
      vld <= 1'b0;
      if (!tick) w[pc] <= s2;
      if (tick) begin
        last3 <= s2;
        for (int i = DELAY - 1; i > 0; i--) dly[i] <= dly[i-1];
        dly[0] <= word;
        dout   <= dly[DELAY-1][sel];
        vld    <= seen;
        if (|e) begin
          seen <= 1'b1;
          cand <= ep;
          run  <= nrun;
          if (nrun == RW'(LOCK_CNT)) sel <= ep + 2'd2;
        end
      end
    end
  end

  // R6
  vld_single_chk: assert property (@(posedge clk) disable iff (rst)
    vld |=> !vld);

  // R5
  vld_needs_edge_chk: assert property (@(posedge clk) disable iff (rst)
    !seen |-> !vld);

  // R8
  dout_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pc != 2'd0) |-> $stable(dout));

  // R8
  phase_when_chk: assert property (@(posedge clk) disable iff (rst)
    (sel != $past(sel)) |-> (pc == 2'd0));

  // R4
  phase_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (sel != $past(sel)) |-> (run == RW'(LOCK_CNT)));
endmodule

// File: tb/sim_quad_phase_rx.sv
`timescale 1ns/1ps
module sim_quad_phase_rx;
  logic clk = 1'b0, rst = 1'b1, din = 1'b0;
  logic dout, vld;
  logic [1:0] phase_o;
  int total = 0, bad = 0;
  bit done = 0;

  quad_phase_rx u0 (.clk(clk), .rst(rst), .din(din), .dout(dout), .vld(vld), .phase_o(phase_o));

  always #2.5 clk = ~clk;

  int ne;
  bit xs[$];
  int m_seen, m_cand, m_run, m_sel;
  bit e_dout, e_vld;

  always @(posedge clk) begin
    int m, ep;
    bit prev;
    if (rst) begin
      ne = 0; xs.delete();
      m_seen = 0; m_cand = 0; m_run = 0; m_sel = 0;
      e_dout = 0; e_vld = 0;
    end else begin
      xs.push_back(din);
      e_vld = 0;
      if (ne % 4 == 1) begin
        m = (ne - 5) / 4;
        e_vld  = (m_seen != 0);
        e_dout = (m >= 4) ? xs[4*(m-4) + m_sel] : 1'b0;
        if (m >= 0) begin
          ep = -1;
          for (int p = 0; p < 4; p++) begin
            if (p == 0) prev = (m == 0) ? 1'b0 : xs[4*m-1];
            else        prev = xs[4*m+p-1];
            if (ep < 0 && xs[4*m+p] != prev) ep = p;
          end
          if (ep >= 0) begin
            if (m_run > 0 && ep == m_cand) begin
              if (m_run < 4) m_run++;
            end else begin
              m_cand = ep; m_run = 1;
            end
            m_seen = 1;
            if (m_run == 4) m_sel = (ep + 2) % 4;
          end
        end
      end
      ne++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(dout === e_dout, "R1/R2/R7/R8 dout", dout, e_dout);
      chk(vld === e_vld, "R5/R6 vld", vld, e_vld);
      chk(phase_o === 2'(m_sel), "R2/R3/R4/R8 phase_o", phase_o, m_sel);
    end
  end

  bit cur = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic stream(input int n, input int off, input int mode);
    for (int i = 0; i < n * 4; i++) begin
      @(negedge clk);
      if (ne % 4 == off) begin
        if (mode == 0) cur = ~cur;
        else if (mode == 1) begin
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          cur = lfsr[0];
        end
      end
      din = cur;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; cur = 0; din = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(phase_o == 2'd0, "R5 phase after reset", phase_o, 0);
    chk(vld == 1'b0, "R5 vld after reset", vld, 0);
    chk(dout == 1'b0, "R5 dout after reset", dout, 0);
  endtask

  initial begin
    do_reset();
    stream(10, 0, 2);
    chk(phase_o == 2'd0, "R5 idle phase", phase_o, 0);
    stream(8, 1, 0);
    chk(phase_o == 2'd3, "R3 lock at phase 1", phase_o, 3);
    stream(1, 3, 0);
    stream(2, 1, 0);
    chk(phase_o == 2'd3, "R4 single jitter ignored", phase_o, 3);
    stream(3, 2, 0);
    chk(phase_o == 2'd3, "R4 three periods no relock", phase_o, 3);
    stream(6, 0, 2);
    chk(phase_o == 2'd3, "R4 quiet periods keep phase", phase_o, 3);
    stream(2, 2, 0);
    stream(1, 0, 2);
    chk(phase_o == 2'd0, "R4 relock after quiet gap", phase_o, 0);
    stream(40, 1, 1);
    stream(40, 3, 1);
    do_reset();
    stream(20, 3, 0);
    chk(phase_o == 2'd1, "R3 lock at phase 3", phase_o, 1);
    stream(30, 2, 1);
    stream(3, 0, 2);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog all act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule